// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a small clocked controller behind a single coin slot that takes nickels and dimes. The coin sensor delivers a one-cycle pulse on `nickel_i` or `dime_i` per coin. The controller adds up credit in steps of 0, 5, 10 and 15 cents. When the credit reaches 15 cents it raises `vend_o` to open the item chute. It returns no change, so a dime that lands on 10 cents of credit still ends at 15 cents. Once `vend_o` is high it stays high until a synchronous reset.

Two parameters choose how the block is built, and neither changes what appears at the ports. `ONE_HOT` selects a dense two-bit credit register or a four-bit register with one bit per credit level. `RETIMED` selects how `vend_o` is produced. With it clear, `vend_o` is decoded from the credit register. With it set, `vend_o` comes straight from its own flip-flop, loaded from the next-state logic. In both forms `vend_o` rises in the same cycle, but in the retimed form no logic sits between the flop and the pin. The coin inputs are plain one-cycle strobes with no handshake, because the sensor cannot be held off.

Top module: `vend_ctrl`

## Requirements
- R1: When `rst` is sampled high at a rising clock edge, credit returns to 0 cents and `vend_o` is low after that edge, whatever the coin inputs are.
- R2: In a cycle with neither coin strobe high, credit is unchanged, so `vend_o` keeps its value.
- R3: A nickel strobe adds 5 cents of credit: 0 goes to 5, 5 goes to 10, and 10 goes to 15.
- R4: A dime strobe at 0 cents gives 10 cents, and a dime strobe at 5 cents gives 15 cents.
- R5: A dime strobe at 10 cents gives 15 cents and no more; the surplus is neither kept nor returned.
- R6: `vend_o` is high exactly when credit is 15 cents. It rises right after the clock edge that takes in the coin that completes 15 cents.
- R7: At 15 cents, credit and `vend_o` stay fixed under any coin strobes until reset.
- R8: With `ONE_HOT`=0 the credit codes are 0c=2'b00, 5c=2'b01, 10c=2'b10 and 15c=2'b11. With `ONE_HOT`=1 credit is held in four bits, exactly one of which is set. The port behaviour is the same for both.
- R9: With `RETIMED`=1, `vend_o` is a flip-flop output loaded from the next-state credit and cleared by reset. Its timing at the port is the same as with `RETIMED`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle strobe per 5-cent coin |
| dime_i | input | 1 | One-cycle strobe per 10-cent coin |
| vend_o | output | 1 | High while 15 cents of credit is held; opens the chute |

## Verification
Every coin sequence of one, two and three coins is applied, with an idle cycle after each coin. This covers every path through 0, 5 and 10 cents. It separates a dime step from a nickel step and shows whether the dime surplus at 10 cents is dropped. Idle cycles confirm that credit holds, and extra coins applied after 15 cents confirm that the full state cannot be left. Each sequence starts from a reset, and a reset applied during a coin strobe shows that reset takes precedence. The same stimulus drives all four encoding and output-timing variants side by side. Any difference in encoding or output timing therefore shows up as a cycle mismatch.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int CREDIT_LEVELS = 4;
  localparam int CREDIT_BITS   = $clog2(CREDIT_LEVELS);

  // Dense credit code; the numeric value is the credit in units of 5 cents.
  typedef enum logic [CREDIT_BITS-1:0] {
    CR_0  = 2'b00,
    CR_5  = 2'b01,
    CR_10 = 2'b10,
    CR_15 = 2'b11
  } credit_t;

  // Next credit for one cycle of strobes. A nickel wins over a dime if both
  // are high (illegal input, kept deterministic only). Full credit is sticky.
  function automatic credit_t credit_step(credit_t cur, logic nickel, logic dime);
    logic [CREDIT_BITS:0] sum;
    logic [CREDIT_BITS:0] add;
    if (cur == CR_15) return CR_15;
    add = nickel ? (CREDIT_BITS+1)'(1) : (dime ? (CREDIT_BITS+1)'(2) : '0);
    sum = {1'b0, cur} + add;
    if (sum >= (CREDIT_BITS+1)'(CREDIT_LEVELS-1)) return CR_15;
    return credit_t'(sum[CREDIT_BITS-1:0]);
  endfunction

endpackage

// File: rtl/vend_credit_core.sv
module vend_credit_core
  import vend_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    nickel,
  input  logic    dime,
  output credit_t credit_now,
  output credit_t credit_next
);

  generate
    if (ONE_HOT) begin : g_onehot
      // bit k set means credit level k (0, 5, 10, 15 cents)
      logic [CREDIT_LEVELS-1:0] oh_q;
      logic [CREDIT_LEVELS-1:0] oh_d;
      logic idle, take_n, take_d;

      assign idle   = ~nickel & ~dime;
      assign take_n = nickel;
      assign take_d = dime & ~nickel;

      always_comb begin
        oh_d[0] = oh_q[0] & idle;
        oh_d[1] = (oh_q[0] & take_n) | (oh_q[1] & idle);
        oh_d[2] = (oh_q[0] & take_d) | (oh_q[1] & take_n) | (oh_q[2] & idle);
        oh_d[3] = (oh_q[1] & take_d) | (oh_q[2] & ~idle) | oh_q[3];
      end

      always_ff @(posedge clk) begin
        if (rst) oh_q <= CREDIT_LEVELS'(1);
        else     oh_q <= oh_d;
      end

      function automatic credit_t oh_decode(logic [CREDIT_LEVELS-1:0] v);
        if (v[3])      return CR_15;
        else if (v[2]) return CR_10;
        else if (v[1]) return CR_5;
        else           return CR_0;
      endfunction

      assign credit_now  = oh_decode(oh_q);
      assign credit_next = oh_decode(oh_d);

      AST_ONEHOT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        $countones(oh_q) == 1) else $error("one-hot credit register corrupt"); // R8
    end else begin : g_binary
      credit_t bin_q;
      credit_t bin_d;

      assign bin_d = credit_step(bin_q, nickel, dime);

      always_ff @(posedge clk) begin
        if (rst) bin_q <= CR_0;
        else     bin_q <= bin_d;
      end

      assign credit_now  = bin_q;
      assign credit_next = bin_d;
    end
  endgenerate

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!nickel && !dime) |=> $stable(credit_now)) else $error("credit moved while idle"); // R2
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (credit_now == CR_15) |=> (credit_now == CR_15)) else $error("left full credit"); // R7
  AST_DIME_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (credit_now == CR_0 && dime && !nickel) |=> (credit_now == CR_10)) else $error("dime at 0c"); // R4
  AST_DIME_AT_TEN: assert property (@(posedge clk) disable iff (rst)
    (credit_now == CR_10 && dime) |=> (credit_now == CR_15)) else $error("dime at 10c"); // R5

endmodule

// File: rtl/vend_release.sv
module vend_release
  import vend_pkg::*;
#(
  parameter bit RETIMED = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  credit_t credit_now,
  input  credit_t credit_next,
  output logic    vend
);

  generate
    if (RETIMED) begin : g_flop
      logic vend_q;
      always_ff @(posedge clk) begin
        vend_q <= ~rst & (credit_next == CR_15);
      end
      assign vend = vend_q;

      AST_FLOP_TRACKS_STATE: assert property (@(posedge clk) disable iff (rst)
        vend == (credit_now == CR_15)) else $error("retimed release out of step"); // R9
    end else begin : g_decode
      assign vend = (credit_now == CR_15);
    end
  endgenerate

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0,
  parameter bit RETIMED = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic vend_o
);

  credit_t credit_now;
  credit_t credit_next;

  vend_credit_core #(.ONE_HOT(ONE_HOT)) u_core (
    .clk        (clk),
    .rst        (rst),
    .nickel     (nickel_i),
    .dime       (dime_i),
    .credit_now (credit_now),
    .credit_next(credit_next)
  );

  vend_release #(.RETIMED(RETIMED)) u_release (
    .clk        (clk),
    .rst        (rst),
    .credit_now (credit_now),
    .credit_next(credit_next),
    .vend       (vend_o)
  );

  AST_VEND_NEEDS_COIN: assert property (@(posedge clk) disable iff (rst)
    $rose(vend_o) |-> $past(nickel_i || dime_i)) else $error("release without coin"); // R6
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (credit_now == CR_0 && !vend_o)) else $error("reset left credit"); // R1

endmodule

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic [3:0] vend;

  int checks = 0;
  int fails  = 0;
  int cred   = 0;   // expected credit in cents
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // R8 binary / R9 decoded
  vend_ctrl #(.ONE_HOT(1'b0), .RETIMED(1'b0)) dut (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .vend_o(vend[0]));
  // R8 binary / R9 retimed
  vend_ctrl #(.ONE_HOT(1'b0), .RETIMED(1'b1)) dut_bin_rt (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .vend_o(vend[1]));
  // R8 one-hot / R9 decoded
  vend_ctrl #(.ONE_HOT(1'b1), .RETIMED(1'b0)) dut_oh (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .vend_o(vend[2]));
  // R8 one-hot / R9 retimed
  vend_ctrl #(.ONE_HOT(1'b1), .RETIMED(1'b1)) dut_oh_rt (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .vend_o(vend[3]));

  function automatic string variant_tag(int k);
    case (k)
      0: return "R8 bin/R9 comb";
      1: return "R8 bin/R9 flop";
      2: return "R8 onehot/R9 comb";
      default: return "R8 onehot/R9 flop";
    endcase
  endfunction

  // One cycle: drive at a falling edge, let one rising edge pass, check.
  task automatic step(input bit r, input bit n, input bit d);
    string tag;
    if (r)                 tag = "R1";
    else if (cred >= 15)   tag = "R7";
    else if (!n && !d)     tag = "R2";
    else if (n)            tag = "R3";
    else if (cred == 10)   tag = "R5";
    else                   tag = "R4";
    rst = r; nickel = n; dime = d;
    if (r)             cred = 0;
    else if (cred < 15) begin
      cred = cred + (n ? 5 : (d ? 10 : 0));
      if (cred > 15) cred = 15;
    end
    if (cred == 15) tag = {tag, "+R6"};
    @(negedge clk);
    rst = 1'b0; nickel = 1'b0; dime = 1'b0;
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (vend[k] !== (cred == 15)) begin
        fails++;
        $display("FAIL %s [%s] credit=%0d vend actual=%b expected=%b",
                 tag, variant_tag(k), cred, vend[k], (cred == 15));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0);              // R1 reset state
    step(1'b0, 1'b0, 1'b0);              // R2 idle at 0c
    // R3 R4 R5 R6 R7: every sequence of 1..3 coins (bit set = dime)
    for (int len = 1; len <= 3; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        step(1'b1, 1'b0, 1'b0);
        for (int c = 0; c < len; c++) begin
          if (pat[c]) step(1'b0, 1'b0, 1'b1);
          else        step(1'b0, 1'b1, 1'b0);
          step(1'b0, 1'b0, 1'b0);
        end
        // back-to-back coins with no idle gap
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
      end
    end
    // R1: reset wins over a coin strobe while full
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule